// File: doc/BRIEF.md
# Tree Partial-Sum Reduction Sequencer

This block folds a set of per-processor partial sums into one total. The sums are first loaded into a register array through a simple write port. A start pulse then supplies an active count. The sequencer works through halving levels. In each level, every lower slot adds in the value held by its partner in the upper half. All additions of a level take effect on the same clock edge, so one level always completes before the next begins.

When the active count is odd, an extra fix-up cycle folds the stray top entry into slot 0 before the halving. Any count from 0 up to the configured processor count is reduced correctly. The total is left in slot 0, which drives the sum output, and a one-cycle done pulse marks completion. The reduction consumes the stored values, so the array must be reloaded before the next run.

Top module: `psum_tree_reducer`

## Requirements
- R1: After reset, busy_o and done_o are 0 and sum_o is 0 (every slot clears to zero).
- R2: While idle, a write with wr_en_i high stores wr_data_i in slot wr_idx_i. Writes presented while busy_o is high are ignored.
- R3: For a power-of-two count c, the sum_o present while done_o is high equals the sum of slots 0..c-1.
- R4: For an odd active count at any level, slot 0 first absorbs slot half-1 in a separate cycle. Non-power-of-two counts therefore give the exact sum of slots 0..c-1.
- R5: Let L be the number of halving levels plus the number of odd fix-ups. busy_o is high for the L+1 cycles that follow the start edge, and done_o rises on the (L+1)-th edge after it.
- R6: done_o is a single-cycle pulse. It rises on the same edge on which busy_o falls.
- R7: start_i is ignored while busy_o is high. The running reduction keeps its count, its result and its timing.
- R8: A count of 0 or 1 finishes one cycle after start, and sum_o then equals slot 0. A count above N is treated as N.
- R9: Additions are 32-bit and wrap modulo 2^32.
- R10: Slots at index c and above have no influence on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Slot write strobe (honoured only when idle) |
| wr_idx_i | input | $clog2(N) | Slot index for the write |
| wr_data_i | input | W | Partial sum to store |
| start_i | input | 1 | Begin a reduction (honoured only when idle) |
| count_i | input | $clog2(N+1) | Number of active slots, sampled at start |
| busy_o | output | 1 | Reduction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sum_o | output | W | Contents of slot 0 (the total once done) |

## Verification
The assertions check the following on every cycle:
- the active count never exceeds N and never grows during a run;
- a fix-up cycle is entered only from an odd count;
- done_o is a single pulse that coincides with the fall of busy_o.

The arithmetic itself can only be shown by the bench's scenarios. These cover the wrapped totals for power-of-two, odd and clamped counts, and the exact completion cycle for each count. They also show that a start or a write issued mid-run leaves both the result and the timing untouched.

// File: rtl/psum_pkg.sv
package psum_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/psum_ctrl.sv
module psum_ctrl
  import psum_pkg::*;
#(
  parameter int N = 64,
  localparam int CNT_W = $clog2(N + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] half_o,
  output logic             fix_en_o,
  output logic             halve_en_o
);
  seq_state_e       state_q;
  logic [CNT_W-1:0] half_q;
  logic             fixed_q;
  logic             done_q;
  logic [CNT_W-1:0] cnt_eff;
  logic             more;

  assign cnt_eff    = (count_i > CNT_W'(N)) ? CNT_W'(N) : count_i;
  assign more       = (half_q > CNT_W'(1));
  assign busy_o     = (state_q == ST_RUN);
  assign fix_en_o   = busy_o && more && half_q[0] && !fixed_q;
  assign halve_en_o = busy_o && more && !fix_en_o;
  assign half_o     = half_q;
  assign done_o     = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      half_q  <= '0;
      fixed_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_RUN;
            half_q  <= cnt_eff;
            fixed_q <= 1'b0;
          end
        end
        ST_RUN: begin
          if (!more) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else if (fix_en_o) begin
            fixed_q <= 1'b1;
          end else begin
            half_q  <= half_q >> 1;
            fixed_q <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R6
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_o); // R6
  AST_BUSY_FALL_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_q); // R6
  AST_HALF_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_q <= CNT_W'(N)); // R8
  AST_HALF_NONINC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (!busy_o || half_q <= $past(half_q))); // R5
  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && more) |=> (busy_o && half_q <= $past(half_q))); // R7
  AST_FIX_ODD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fixed_q) |-> $past(half_q[0])); // R4
endmodule

// File: rtl/psum_fold_array.sv
module psum_fold_array #(
  parameter int N = 64,
  parameter int W = 32,
  localparam int IDX_W = $clog2(N),
  localparam int CNT_W = $clog2(N + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [W-1:0]     wr_data_i,
  input  logic [CNT_W-1:0] half_i,
  input  logic             fix_en_i,
  input  logic             halve_en_i,
  output logic [W-1:0]     slot0_o
);
  logic [W-1:0]     mem_q   [N];
  logic [W-1:0]     partner [N];
  logic [W-1:0]     tail;
  logic [CNT_W-1:0] nh;

  assign nh      = half_i >> 1;
  assign slot0_o = mem_q[0];

  always_comb begin
    tail = '0;
    if (half_i != '0) tail = mem_q[IDX_W'(half_i - CNT_W'(1))];
  end

  always_comb begin
    for (int p = 0; p < N; p++) begin
      partner[p] = '0;
      if (p + int'(nh) < N) partner[p] = mem_q[IDX_W'(p + int'(nh))];
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic wr_hit;
    logic fold_hit;
    assign wr_hit   = wr_en_i && (wr_idx_i == IDX_W'(g));
    assign fold_hit = halve_en_i && (CNT_W'(g) < nh);

    if (g == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       mem_q[g] <= '0;
        else if (wr_hit)   mem_q[g] <= wr_data_i;
        else if (fix_en_i) mem_q[g] <= mem_q[g] + tail;
        else if (fold_hit) mem_q[g] <= mem_q[g] + partner[g];
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       mem_q[g] <= '0;
        else if (wr_hit)   mem_q[g] <= wr_data_i;
        else if (fold_hit) mem_q[g] <= mem_q[g] + partner[g];
      end
    end
  end

  AST_FIX_HALVE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fix_en_i && halve_en_i)); // R4
  AST_NO_WRITE_IN_FOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fix_en_i || halve_en_i) |-> !wr_en_i); // R2
endmodule

// File: rtl/psum_tree_reducer.sv
module psum_tree_reducer #(
  parameter int N = 64,
  parameter int W = 32,
  localparam int IDX_W = $clog2(N),
  localparam int CNT_W = $clog2(N + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [W-1:0]     wr_data_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [W-1:0]     sum_o
);
  logic [CNT_W-1:0] half;
  logic             fix_en;
  logic             halve_en;
  logic             wr_ok;

  assign wr_ok = wr_en_i && !busy_o;

  psum_ctrl #(.N(N)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .count_i    (count_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .half_o     (half),
    .fix_en_o   (fix_en),
    .halve_en_o (halve_en)
  );

  psum_fold_array #(.N(N), .W(W)) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_ok),
    .wr_idx_i   (wr_idx_i),
    .wr_data_i  (wr_data_i),
    .half_i     (half),
    .fix_en_i   (fix_en),
    .halve_en_i (halve_en),
    .slot0_o    (sum_o)
  );

  AST_SUM_HELD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !wr_en_i) |=> $stable(sum_o)); // R2
endmodule

// File: tb/psum_tree_reducer_test.sv
module psum_tree_reducer_test;
  localparam int N = 64;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [5:0]    wr_idx = '0;
  logic [W-1:0]  wr_data = '0;
  logic          start = 1'b0;
  logic [6:0]    count = '0;
  logic          busy, done;
  logic [W-1:0]  sum;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic [W-1:0] ref_mem [N];

  always #2.5 clk = ~clk;

  psum_tree_reducer #(.N(N), .W(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .start_i(start), .count_i(count),
    .busy_o(busy), .done_o(done), .sum_o(sum)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, 100000);
      finish_run();
    end
  end

  task automatic load(input int mode);
    for (int i = 0; i < N; i++) begin
      case (mode)
        0: ref_mem[i] = W'(i + 1);
        1: ref_mem[i] = W'(i * 37 + 5) ^ (W'(i) << 20);
        default: ref_mem[i] = '1;
      endcase
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 6'(i); wr_data = ref_mem[i];
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Behavioural model: expected total and level-by-level latency.
  task automatic reduce(input int cnt, input string req, input bit poke);
    int h = (cnt > N) ? N : cnt;
    int ops = 0;
    logic [W-1:0] exp = ref_mem[0];
    if (h > 1) begin
      exp = '0;
      for (int i = 0; i < h; i++) exp += ref_mem[i];
    end
    while (h > 1) begin
      if (h % 2 == 1) ops++;
      h = h / 2;
      ops++;
    end
    @(negedge clk);
    start = 1'b1; count = 7'(cnt);
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= ops + 2; k++) begin
      if (poke && k == 1) begin
        start = 1'b1; count = 7'd3;
        wr_en = 1'b1; wr_idx = 6'd0; wr_data = 32'hDEAD_BEEF;
      end
      @(negedge clk);
      start = 1'b0; wr_en = 1'b0;
      chk(busy == (k <= ops), "R5 busy", W'(busy), W'(k <= ops));
      chk(done == (k == ops + 1), "R6 done", W'(done), W'(k == ops + 1));
      if (k == ops + 1) chk(sum == exp, req, sum, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy, "R1 busy", W'(busy), 0);
    chk(!done, "R1 done", W'(done), 0);
    chk(sum == '0, "R1 sum", sum, 0);
    rst_n = 1'b1;

    load(0); reduce(64, "R3 c64", 1'b0);
    load(0); reduce(2, "R3 c2", 1'b0);
    load(0); reduce(16, "R3 c16", 1'b0);
    load(1); reduce(37, "R4 c37", 1'b0);
    load(1); reduce(5, "R4 c5", 1'b0);
    load(1); reduce(3, "R4 c3", 1'b0);
    load(1); reduce(63, "R4 c63", 1'b0);
    load(1); reduce(10, "R10 c10", 1'b0);
    load(1); reduce(1, "R8 c1", 1'b0);
    load(1); reduce(0, "R8 c0", 1'b0);
    load(1); reduce(100, "R8 clamp", 1'b0);
    load(2); reduce(64, "R9 wrap", 1'b0);
    load(1); reduce(64, "R7 R2 poke", 1'b1);

    @(negedge clk);
    wr_en = 1'b1; wr_idx = 6'd0; wr_data = 32'h0000_1234;
    ref_mem[0] = 32'h0000_1234;
    @(negedge clk);
    wr_en = 1'b0;
    reduce(1, "R2 write", 1'b0);

    finish_run();
  end
endmodule